// File: doc/BRIEF.md
# Flash Bus Write Qualifier and Identifier Readout

This block is the device-side front end of a parallel NOR flash model. It samples the three active-low bus strobes (chip enable, output enable, write enable) on a local clock. A strobe change counts only after it has held for a set number of sample cycles, so short noise pulses are dropped. A write cycle starts only when chip enable and write enable are both low while output enable is high. When write enable is released in a write cycle that is still valid, the block sends a one-cycle write pulse to the downstream command decoder. The pulse carries the address latched when the cycle started and the last data sampled during it. A strobe combination that is already writing when reset is released stays locked out until it is fully withdrawn.

On the read side the block passes array data straight through by default. It can also switch to an identifier readout. This mode is entered either by a high-voltage indicator on address line 9 or by enter and exit pulses from the external command decoder. In this mode the low address bits select the manufacturer, device or continuation code. The boot-block variant and the byte/word bus width are static inputs.

Top module: `flash_bus_front`

## Requirements
- R1: Once chip enable and write enable are both low with output enable high for at least GLITCH_CYC sample cycles, releasing write enable (high for at least GLITCH_CYC cycles) gives exactly one wr_pulse_o. The pulse carries the address present when the cycle was qualified and the data held during it.
- R2: No write pulse is produced if output enable is low at any qualified point of the cycle, whether it is low from the start or goes low while write enable is still low.
- R3: A low pulse on write enable shorter than GLITCH_CYC sample cycles starts no write. A high glitch on write enable that is shorter than GLITCH_CYC inside a write cycle does not end that cycle, so only one pulse is produced.
- R4: If chip enable and write enable are low and output enable is high when reset is released, the later rise of write enable produces no pulse. Writes are accepted again after that combination has been withdrawn.
- R5: If chip enable rises while write enable is still low, the cycle is abandoned and no pulse is produced.
- R6: After reset the identifier mode is off (id_mode_o = 0) and rd_data_o equals array_data_i.
- R7: While hv_a9_i is high, identifier mode is active.
- R8: An id_enter_i pulse turns identifier mode on and an id_exit_i pulse turns it off; exit wins if both occur in the same cycle. Reset clears the mode.
- R9: In identifier mode with addr_i[6] = 0, {addr_i[1], addr_i[0]} selects the output: 00 gives 16'h0037, 11 gives 16'h007F, and 01 gives the device code in the low byte (8'h1A if boot_top_i = 1, 8'h9B if 0). The high byte of the device code is 8'hB3 when word_mode_i = 1 and 8'h00 otherwise.
- R10: In identifier mode, rd_data_o is 16'h0000 when addr_i[6] = 1 or when {addr_i[1], addr_i[0]} = 10.
- R11: rd_drive_o is high exactly when ce_ni = 0, oe_ni = 0 and we_ni = 1.
- R12: wr_pulse_o is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| ce_ni | input | 1 | Chip enable strobe, active low |
| oe_ni | input | 1 | Output enable strobe, active low |
| we_ni | input | 1 | Write enable strobe, active low |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 16 | Bus write data |
| hv_a9_i | input | 1 | High-voltage indicator on address line 9 |
| id_enter_i | input | 1 | Command-path request to enter identifier mode |
| id_exit_i | input | 1 | Command-path request to leave identifier mode |
| boot_top_i | input | 1 | Boot-block variant: 1 top, 0 bottom |
| word_mode_i | input | 1 | Bus width: 1 word, 0 byte |
| array_data_i | input | 16 | Read data from the array |
| rd_data_o | output | 16 | Read data toward the bus |
| rd_drive_o | output | 1 | Read data should be driven on the bus |
| wr_pulse_o | output | 1 | One-cycle qualified write pulse |
| wr_addr_o | output | ADDR_W | Address carried with the write pulse |
| wr_data_o | output | 16 | Data carried with the write pulse |
| id_mode_o | output | 1 | Identifier mode active |

## Verification
The assertions check on every cycle that a filtered strobe only moves to a level the raw strobe held in the previous sample, and that the write pulse never lasts two cycles. They also check that no pulse follows the power-up lockout or an abandoned cycle, and that identifier reads give only legal code bytes. Whether a strobe sequence as a whole yields zero or one pulse can only be shown by the bench's scenarios. The same holds for the latched address and data, glitch widths on either side of the threshold, the lockout at reset release, and the enter/exit/reset history of identifier mode.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int unsigned DATA_W = 16;

  localparam logic [7:0] MANUF_CODE  = 8'h37;
  localparam logic [7:0] DEV_TOP     = 8'h1A;
  localparam logic [7:0] DEV_BOTTOM  = 8'h9B;
  localparam logic [7:0] DEV_HI_WORD = 8'hB3;
  localparam logic [7:0] CONT_CODE   = 8'h7F;

  typedef enum logic [1:0] {
    ST_LOCK   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ACTIVE = 2'd2
  } wq_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobes_t;

  function automatic logic write_combo(strobes_t s);
    return !s.ce_n && !s.we_n && s.oe_n;
  endfunction
endpackage

// File: rtl/fe_strobe_filter.sv
module fe_strobe_filter #(
  parameter int unsigned GLITCH_CYC = 4,
  parameter logic        RST_VAL    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CNT_W = $clog2(GLITCH_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYC - 1);

  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  // new level must persist GLITCH_CYC consecutive samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(raw_i) == filt_q)); // R3
endmodule

// File: rtl/fe_write_qual.sv
module fe_write_qual
  import flash_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobes_t          raw_i,
  input  strobes_t          filt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_pulse_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  wq_state_e         state_q, state_d;
  logic              pulse_q, pulse_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              combo_f, combo_raw;

  assign combo_f   = write_combo(filt_i);
  assign combo_raw = write_combo(raw_i);

  always_comb begin
    state_d = state_q;
    pulse_d = 1'b0;
    addr_d  = addr_q;
    data_d  = data_q;
    unique case (state_q)
      ST_LOCK: begin
        // wait until the power-up write combination is fully gone
        if (!combo_f && !combo_raw) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (combo_f) begin
          state_d = ST_ACTIVE;
          addr_d  = addr_i;
          data_d  = data_i;
        end
      end
      ST_ACTIVE: begin
        if (!filt_i.oe_n) begin
          state_d = ST_IDLE;
        end else if (filt_i.we_n) begin
          state_d = ST_IDLE;
          pulse_d = 1'b1;
        end else if (filt_i.ce_n) begin
          state_d = ST_IDLE;
        end else begin
          data_d = data_i;
        end
      end
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      pulse_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign wr_pulse_o = pulse_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R12
  AST_LOCK_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK) |=> !pulse_q); // R4
  AST_ABORT_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && filt_i.ce_n && !filt_i.we_n) |=> !pulse_q); // R5
  AST_OE_LOW_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !filt_i.oe_n) |=> !pulse_q); // R2
endmodule

// File: rtl/fe_id_mux.sv
module fe_id_mux
  import flash_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hv_a9_i,
  input  logic              id_enter_i,
  input  logic              id_exit_i,
  input  logic              a6_i,
  input  logic [1:0]        sel_i,
  input  logic              boot_top_i,
  input  logic              word_mode_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              id_mode_o
);
  logic             cmd_q;
  logic             id_mode;
  logic [DATA_W-1:0] id_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cmd_q <= 1'b0;
    else if (id_exit_i)  cmd_q <= 1'b0;
    else if (id_enter_i) cmd_q <= 1'b1;
  end

  assign id_mode = hv_a9_i | cmd_q;

  always_comb begin
    id_word = '0;
    if (!a6_i) begin
      unique case (sel_i)
        2'b00: id_word = {8'h00, MANUF_CODE};
        2'b01: id_word = {word_mode_i ? DEV_HI_WORD : 8'h00,
                          boot_top_i ? DEV_TOP : DEV_BOTTOM};
        2'b11: id_word = {8'h00, CONT_CODE};
        default: id_word = '0;
      endcase
    end
  end

  assign rd_data_o = id_mode ? id_word : array_data_i;
  assign id_mode_o = id_mode;

  AST_ID_LEGAL_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_o && !a6_i) |-> (rd_data_o[7:0] == 8'h37 || rd_data_o[7:0] == 8'h1A ||
                              rd_data_o[7:0] == 8'h9B || rd_data_o[7:0] == 8'h7F ||
                              rd_data_o[7:0] == 8'h00)); // R9
  AST_ID_EXIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_exit_i && !hv_a9_i) |=> (!id_mode_o || hv_a9_i)); // R8
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_fe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              hv_a9_i,
  input  logic              id_enter_i,
  input  logic              id_exit_i,
  input  logic              boot_top_i,
  input  logic              word_mode_i,
  input  logic [15:0]       array_data_i,
  output logic [15:0]       rd_data_o,
  output logic              rd_drive_o,
  output logic              wr_pulse_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  output logic              id_mode_o
);
  localparam int unsigned N_STROBE = 3;

  strobes_t             raw_s, filt_s;
  logic [N_STROBE-1:0]  raw_v, filt_v;

  assign raw_s = '{ce_n: ce_ni, oe_n: oe_ni, we_n: we_ni};
  assign raw_v = raw_s;
  assign filt_s = filt_v;

  for (genvar g = 0; g < N_STROBE; g++) begin : g_filt
    fe_strobe_filter #(
      .GLITCH_CYC (GLITCH_CYC),
      .RST_VAL    (1'b1)
    ) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_v[g]),
      .filt_o (filt_v[g])
    );
  end

  fe_write_qual #(
    .ADDR_W (ADDR_W)
  ) i_wq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (raw_s),
    .filt_i     (filt_s),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .wr_pulse_o (wr_pulse_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  fe_id_mux i_id (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hv_a9_i      (hv_a9_i),
    .id_enter_i   (id_enter_i),
    .id_exit_i    (id_exit_i),
    .a6_i         (addr_i[6]),
    .sel_i        (addr_i[1:0]),
    .boot_top_i   (boot_top_i),
    .word_mode_i  (word_mode_i),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o),
    .id_mode_o    (id_mode_o)
  );

  assign rd_drive_o = !ce_ni && !oe_ni && we_ni;
endmodule

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;
  localparam int AW = 19;
  localparam int G  = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic          hv = 1'b0, ent = 1'b0, ext = 1'b0, top = 1'b1, word = 1'b1;
  logic [15:0]   arr = 16'h1234;
  logic [15:0]   rd_data;
  logic          rd_drive, wr_pulse, id_mode;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;

  int n_chk = 0, n_bad = 0;
  int pulses = 0, width_err = 0;
  logic          prev_p = 1'b0;
  logic [AW-1:0] cap_addr;
  logic [15:0]   cap_data;
  logic          cmd_m = 1'b0;

  always #2 clk = ~clk;

  flash_bus_front #(.ADDR_W(AW), .GLITCH_CYC(G)) i_flash_bus_front (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .addr_i(addr), .data_i(wdata), .hv_a9_i(hv), .id_enter_i(ent), .id_exit_i(ext),
    .boot_top_i(top), .word_mode_i(word), .array_data_i(arr),
    .rd_data_o(rd_data), .rd_drive_o(rd_drive), .wr_pulse_o(wr_pulse),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .id_mode_o(id_mode));

  always @(negedge clk) begin
    if (wr_pulse) begin
      pulses++;
      cap_addr = wr_addr;
      cap_data = wr_data;
      if (prev_p) width_err++;
    end
    prev_p = wr_pulse;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_rd(logic idm, logic [AW-1:0] a, logic t,
                                         logic w, logic [15:0] ar);
    if (!idm) return ar;
    if (a[6]) return 16'h0000;
    case (a[1:0])
      2'b00: return 16'h0037;
      2'b01: return {w ? 8'hB3 : 8'h00, t ? 8'h1A : 8'h9B};
      2'b11: return 16'h007F;
      default: return 16'h0000;
    endcase
  endfunction

  // write cycle with WE low for low_n cycles; returns pulses seen
  task automatic do_write(logic [AW-1:0] a, logic [15:0] d, int low_n, output int got);
    int p0;
    p0 = pulses;
    @(negedge clk);
    addr = a; wdata = d; ce_ni = 1'b0;
    cyc(1);
    we_ni = 1'b0;
    cyc(low_n);
    we_ni = 1'b1;
    cyc(2 * G + 4);
    ce_ni = 1'b1;
    cyc(G + 3);
    got = pulses - p0;
  endtask

  initial begin
    int got, p0, low;
    logic [AW-1:0] a;
    logic [15:0] d;
    void'($urandom(32'd20240611));

    // power-up with a write combination already present
    ce_ni = 1'b0; we_ni = 1'b0; oe_ni = 1'b1;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R6 id_mode after reset", {31'd0, id_mode}, 32'd0);
    chk("R6 array pass after reset", {16'd0, rd_data}, {16'd0, arr});
    p0 = pulses;
    cyc(10);
    we_ni = 1'b1;
    cyc(3 * G);
    ce_ni = 1'b1;
    cyc(G + 3);
    chk("R4 no pulse after power-up combo", pulses - p0, 0);

    do_write(19'h2AAA, 16'h55AA, 8, got);
    chk("R1 pulse count", got, 1);
    chk("R1 addr", {13'd0, cap_addr}, {13'd0, 19'h2AAA});
    chk("R1 data", {16'd0, cap_data}, {16'd0, 16'h55AA});
    chk("R4 writes resume after lockout", got, 1);

    do_write(19'h0555, 16'h00F0, G - 1, got);
    chk("R3 short WE low ignored", got, 0);
    do_write(19'h0555, 16'h0090, G, got);
    chk("R3 WE low at threshold accepted", got, 1);

    // high glitch on WE inside a cycle
    p0 = pulses;
    @(negedge clk); addr = 19'h1111; wdata = 16'hBEEF; ce_ni = 1'b0;
    cyc(1); we_ni = 1'b0; cyc(8);
    we_ni = 1'b1; cyc(G - 2); we_ni = 1'b0; cyc(6);
    we_ni = 1'b1; cyc(2 * G + 4); ce_ni = 1'b1; cyc(G + 3);
    chk("R3 WE high glitch keeps cycle", pulses - p0, 1);
    chk("R1 data after glitch", {16'd0, cap_data}, {16'd0, 16'hBEEF});

    // OE low from start
    p0 = pulses;
    @(negedge clk); oe_ni = 1'b0; ce_ni = 1'b0; cyc(1); we_ni = 1'b0; cyc(8);
    we_ni = 1'b1; cyc(2 * G + 4); ce_ni = 1'b1; oe_ni = 1'b1; cyc(G + 3);
    chk("R2 OE low from start", pulses - p0, 0);
    // OE falls mid cycle
    p0 = pulses;
    @(negedge clk); ce_ni = 1'b0; cyc(1); we_ni = 1'b0; cyc(8);
    oe_ni = 1'b0; cyc(8); we_ni = 1'b1; cyc(2 * G + 4);
    oe_ni = 1'b1; cyc(2 * G); ce_ni = 1'b1; cyc(G + 3);
    chk("R2 OE low mid cycle", pulses - p0, 0);
    // CE rises first
    p0 = pulses;
    @(negedge clk); ce_ni = 1'b0; cyc(1); we_ni = 1'b0; cyc(8);
    ce_ni = 1'b1; cyc(2 * G + 2); we_ni = 1'b1; cyc(2 * G + 4);
    chk("R5 CE rise abandons cycle", pulses - p0, 0);

    // random writes
    for (int k = 0; k < 30; k++) begin
      a = AW'($urandom); d = 16'($urandom); low = 1 + int'($urandom % 8);
      do_write(a, d, low, got);
      chk("R1 R3 random write count", got, (low >= G) ? 1 : 0);
      if (low >= G) begin
        chk("R1 random addr", {13'd0, cap_addr}, {13'd0, a});
        chk("R1 random data", {16'd0, cap_data}, {16'd0, d});
      end
    end

    // R11 drive
    @(negedge clk); ce_ni = 1'b0; oe_ni = 1'b0; #1;
    chk("R11 drive on read", {31'd0, rd_drive}, 32'd1);
    we_ni = 1'b0; #1;
    chk("R11 no drive with WE low", {31'd0, rd_drive}, 32'd0);
    we_ni = 1'b1; ce_ni = 1'b1; #1;
    chk("R11 no drive with CE high", {31'd0, rd_drive}, 32'd0);
    oe_ni = 1'b1;
    cyc(G + 3);

    // identifier directed
    @(negedge clk); hv = 1'b1; addr = '0; #1;
    chk("R7 hv enters id", {31'd0, id_mode}, 32'd1);
    chk("R9 manuf", {16'd0, rd_data}, 32'h0037);
    addr = 19'h00001; top = 1'b0; word = 1'b0; #1;
    chk("R9 bottom byte", {16'd0, rd_data}, 32'h009B);
    word = 1'b1; top = 1'b1; #1;
    chk("R9 top word", {16'd0, rd_data}, 32'hB31A);
    addr = 19'h00003; #1;
    chk("R9 continuation", {16'd0, rd_data}, 32'h007F);
    addr = 19'h00043; #1;
    chk("R10 A6 high", {16'd0, rd_data}, 32'h0000);
    addr = 19'h00002; #1;
    chk("R10 sel 10", {16'd0, rd_data}, 32'h0000);
    hv = 1'b0;
    @(negedge clk); ent = 1'b1; ext = 1'b1;
    @(negedge clk); ent = 1'b0; ext = 1'b0;
    chk("R8 exit wins", {31'd0, id_mode}, 32'd0);
    @(negedge clk); ent = 1'b1;
    @(negedge clk); ent = 1'b0;
    chk("R8 enter", {31'd0, id_mode}, 32'd1);
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(1);
    chk("R8 reset clears mode", {31'd0, id_mode}, 32'd0);
    chk("R6 array after reset", {16'd0, rd_data}, {16'd0, arr});

    // random identifier reads
    cmd_m = 1'b0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      ent = ($urandom % 5) == 0; ext = ($urandom % 5) == 0;
      @(negedge clk);
      if (ext) cmd_m = 1'b0; else if (ent) cmd_m = 1'b1;
      ent = 1'b0; ext = 1'b0;
      hv = ($urandom % 3) == 0; addr = AW'($urandom); top = 1'($urandom);
      word = 1'($urandom); arr = 16'($urandom);
      #1;
      chk("R7 R8 random id_mode", {31'd0, id_mode}, {31'd0, hv | cmd_m});
      chk("R9 R10 random read", {16'd0, rd_data},
          {16'd0, exp_rd(hv | cmd_m, addr, top, word, arr)});
    end

    chk("R12 pulse width", width_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule